// File: doc/BRIEF.md
# Decoded Integer ALU Stage

This block is the execute step for the register and immediate arithmetic group of a 32-bit RISC integer pipeline. Each cycle it takes one instruction word and the two register operand values the register file has already read for it. It decodes the instruction's primary opcode and, for register-format words, the function code. It then forms the second operand: either the second register, or the 16-bit immediate widened by sign or zero extension as that opcode requires. Finally it computes the result.

After one register stage it presents a write-back request: a valid flag, a write enable, a destination register index and the result. Memory, branch, jump and multiply/divide encodings are not executed. Such words, and any encoding the block does not know, still flow through with the valid flag set, but with the write enable low. A write aimed at register 0 is suppressed the same way, so the hard-wired zero register is never disturbed.

Top module: `ialu_stage`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output (`out_valid`, `wr_en`, `wr_idx`, `wr_data`) is 0 after that edge.
- R2: Opcode bits 31:26 = 0 with function bits 5:0 = 0x21 writes `rs_val + rt_val`, and function 0x23 writes `rs_val - rt_val`. Both wrap modulo 2^32 and never raise any exception.
- R3: Opcode 0 with function 0x25 writes `rs_val | rt_val`, function 0x26 writes `rs_val ^ rt_val`, and function 0x27 writes `~(rs_val | rt_val)`.
- R4: Opcode 0 with function 0x00, 0x02 or 0x03 shifts `rt_val` by the amount in bits 10:6. Function 0x00 shifts left, 0x02 shifts right filling with zeros, and 0x03 shifts right filling with copies of bit 31. `rs_val` has no effect on these.
- R5: Opcode 0x09 writes `rs_val` plus the immediate in bits 15:0 sign-extended to 32 bits, wrapping modulo 2^32.
- R6: Opcode 0x0C writes `rs_val` AND the zero-extended immediate. Opcode 0x0D writes `rs_val` OR the zero-extended immediate.
- R7: Opcode 0x0F writes the immediate in bits 31:16 of the result, with bits 15:0 zero and `rs_val` ignored.
- R8: For opcode 0 the destination index is bits 15:11. For opcodes 0x09, 0x0C, 0x0D and 0x0F it is bits 20:16.
- R9: Any other opcode, and any opcode-0 word whose function is not one of 0x00, 0x02, 0x03, 0x21, 0x23, 0x25, 0x26, 0x27, gives `wr_en` = 0.
- R10: A supported instruction whose destination index is 0 gives `wr_en` = 0.
- R11: `out_valid` equals `in_valid` of the previous cycle, and all results appear one cycle after the inputs. `wr_en` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | DATA_W | Value of the first source register |
| rt_val | input | DATA_W | Value of the second source register |
| out_valid | output | 1 | Registered copy of `in_valid` |
| wr_en | output | 1 | Register write-back request |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | DATA_W | Computed result |

## Verification
A supported operation and the register-0 write suppression can apply to the same instruction. Then the arithmetic result is formed while the write must still be blocked. The bench provokes this with an add whose destination field is 0 and a load-upper-immediate whose target field is 0, placed between ordinary writes so that no blocked slot leaks into a neighbour. Each is judged by `out_valid` high with `wr_en` low in the following cycle. The same pattern is applied to rejected encodings that look like supported ones (function 0x20 and 0x24, opcode 0x08).

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;

  typedef enum logic [3:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR,
    FN_XOR,
    FN_NOR,
    FN_SLL,
    FN_SRL,
    FN_SRA,
    FN_LUI
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e           fn;
    logic              use_imm;
    logic              imm_sign;
    logic [REG_AW-1:0] dst;
    logic              ok;
  } dec_t;

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
  import ialu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  always_comb begin
    dec.fn       = FN_ADD;
    dec.use_imm  = 1'b0;
    dec.imm_sign = 1'b0;
    dec.dst      = instr[15:11];
    dec.ok       = 1'b0;
    unique case (opcode)
      6'h00: begin
        dec.ok = 1'b1;
        unique case (funct)
          6'h21:   dec.fn = FN_ADD;
          6'h23:   dec.fn = FN_SUB;
          6'h25:   dec.fn = FN_OR;
          6'h26:   dec.fn = FN_XOR;
          6'h27:   dec.fn = FN_NOR;
          6'h00:   dec.fn = FN_SLL;
          6'h02:   dec.fn = FN_SRL;
          6'h03:   dec.fn = FN_SRA;
          default: dec.ok = 1'b0;
        endcase
      end
      6'h09: begin
        dec.fn       = FN_ADD;
        dec.use_imm  = 1'b1;
        dec.imm_sign = 1'b1;
        dec.dst      = instr[20:16];
        dec.ok       = 1'b1;
      end
      6'h0C: begin
        dec.fn      = FN_AND;
        dec.use_imm = 1'b1;
        dec.dst     = instr[20:16];
        dec.ok      = 1'b1;
      end
      6'h0D: begin
        dec.fn      = FN_OR;
        dec.use_imm = 1'b1;
        dec.dst     = instr[20:16];
        dec.ok      = 1'b1;
      end
      6'h0F: begin
        dec.fn      = FN_LUI;
        dec.use_imm = 1'b1;
        dec.dst     = instr[20:16];
        dec.ok      = 1'b1;
      end
      default: dec.ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/ialu_operand.sv
module ialu_operand #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              imm_sign,
  input  logic [DATA_W-1:0] rt_val,
  output logic [DATA_W-1:0] opb
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] imm_zx;

  assign imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign imm_zx = {{PAD_W{1'b0}}, imm};

  always_comb begin
    if (!use_imm)      opb = rt_val;
    else if (imm_sign) opb = imm_sx;
    else               opb = imm_zx;
  end

endmodule

// File: rtl/ialu_core.sv
module ialu_core
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [4:0]        shamt,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    unique case (fn)
      FN_ADD:  result = opa + opb;
      FN_SUB:  result = opa - opb;
      FN_AND:  result = opa & opb;
      FN_OR:   result = opa | opb;
      FN_XOR:  result = opa ^ opb;
      FN_NOR:  result = ~(opa | opb);
      FN_SLL:  result = opb << shamt;
      FN_SRL:  result = opb >> shamt;
      FN_SRA:  result = DATA_W'($signed(opb) >>> shamt);
      FN_LUI:  result = opb << IMM_W;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/ialu_stage.sv
module ialu_stage
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [INSTR_W-1:0]    instr,
  input  logic [DATA_W-1:0]     rs_val,
  input  logic [DATA_W-1:0]     rt_val,
  output logic                  out_valid,
  output logic                  wr_en,
  output logic [REG_AW-1:0]     wr_idx,
  output logic [DATA_W-1:0]     wr_data
);

  dec_t              dec;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] result;
  logic              unused_rs_field;

  assign unused_rs_field = ^instr[25:21];

  ialu_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  ialu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
    .imm      (instr[IMM_W-1:0]),
    .use_imm  (dec.use_imm),
    .imm_sign (dec.imm_sign),
    .rt_val   (rt_val),
    .opb      (opb)
  );

  ialu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .fn     (dec.fn),
    .opa    (rs_val),
    .opb    (opb),
    .shamt  (instr[10:6]),
    .result (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && dec.ok && (dec.dst != '0);
      wr_idx    <= dec.dst;
      wr_data   <= result;
    end
  end

  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid) else $error("wr_en without out_valid"); // R11

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("out_valid did not follow in_valid"); // R11

  AST_UNSUP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec.ok) |=> !wr_en) else $error("unsupported encoding wrote"); // R9

  AST_ZERO_DEST_RTYPE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'h00 && instr[15:11] == 5'd0) |=> !wr_en)
    else $error("write to register 0"); // R10

  AST_UPPER_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'h0F) |=> (wr_data[IMM_W-1:0] == '0))
    else $error("upper-immediate low half not zero"); // R7

endmodule

// File: tb/ialu_stage_tb_top.sv
module ialu_stage_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic        out_valid;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit summary_done = 1'b0;

  typedef struct {
    logic        v;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  ialu_stage dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  function automatic logic [31:0] r_ins(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [4:0] sh,
                                        input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] i_ins(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic issue(input logic v, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic we, input logic [4:0] idx,
                       input logic [31:0] data, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v;
    instr    = ins;
    rs_val   = a;
    rt_val   = b;
    e.v = v; e.we = we; e.idx = idx; e.data = data; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    issue(1'b0, r_ins(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'd1, 32'd1, 1'b0, 5'd0, 32'd0, "R11 idle");
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
    end
  endtask

  // monitor: pops one expected item per cycle and compares
  always @(posedge clk) begin
    #2;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (out_valid !== e.v || wr_en !== e.we ||
          (e.we && (wr_idx !== e.idx || wr_data !== e.data))) begin
        fails++;
        $display("FAIL %s: got v=%0b we=%0b idx=%0d data=%h, expected v=%0b we=%0b idx=%0d data=%h",
                 e.tag, out_valid, wr_en, wr_idx, wr_data, e.v, e.we, e.idx, e.data);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got run still busy, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || wr_idx !== 5'd0 || wr_data !== 32'd0) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b we=%0b idx=%0d data=%h, expected all zero",
               out_valid, wr_en, wr_idx, wr_data);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2 add and subtract, with wrap
    issue(1, r_ins(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'h5, 32'h7, 1, 5'd3, 32'hC, "R2 add");
    issue(1, r_ins(5'd1, 5'd2, 5'd4, 5'd0, 6'h21), 32'hFFFF_FFFF, 32'h2, 1, 5'd4, 32'h1, "R2 add wrap");
    issue(1, r_ins(5'd1, 5'd2, 5'd5, 5'd0, 6'h23), 32'h3, 32'h5, 1, 5'd5, 32'hFFFF_FFFE, "R2 sub wrap");
    idle();
    // R3 logic
    issue(1, r_ins(5'd1, 5'd2, 5'd6, 5'd0, 6'h25), 32'hF0F0_0000, 32'h0F0F_00FF, 1, 5'd6, 32'hFFFF_00FF, "R3 or");
    issue(1, r_ins(5'd1, 5'd2, 5'd7, 5'd0, 6'h26), 32'hFF00_FF00, 32'h0FF0_0FF0, 1, 5'd7, 32'hF0F0_F0F0, "R3 xor");
    issue(1, r_ins(5'd1, 5'd2, 5'd8, 5'd0, 6'h27), 32'hFFFF_0000, 32'h0000_00FF, 1, 5'd8, 32'h0000_FF00, "R3 nor");
    // R4 shifts, rs_val must not matter
    issue(1, r_ins(5'd1, 5'd2, 5'd9, 5'd4, 6'h00), 32'hDEAD_BEEF, 32'h3, 1, 5'd9, 32'h30, "R4 sll");
    issue(1, r_ins(5'd1, 5'd2, 5'd10, 5'd31, 6'h02), 32'hFFFF_FFFF, 32'h8000_0000, 1, 5'd10, 32'h1, "R4 srl");
    issue(1, r_ins(5'd1, 5'd2, 5'd11, 5'd4, 6'h03), 32'h0, 32'h8000_0000, 1, 5'd11, 32'hF800_0000, "R4 sra neg");
    issue(1, r_ins(5'd1, 5'd2, 5'd12, 5'd1, 6'h03), 32'h0, 32'h4000_0000, 1, 5'd12, 32'h2000_0000, "R4 sra pos");
    idle();
    // R5 sign-extended add; R8 dest from bits 20:16 (bits 15:11 are 31 here)
    issue(1, i_ins(6'h09, 5'd1, 5'd13, 16'hFFFF), 32'd10, 32'h1234, 1, 5'd13, 32'd9, "R5 R8 addiu neg");
    issue(1, i_ins(6'h09, 5'd1, 5'd14, 16'h0001), 32'h7FFF_FFFF, 32'h0, 1, 5'd14, 32'h8000_0000, "R5 addiu wrap");
    // R6 zero-extended logic
    issue(1, i_ins(6'h0C, 5'd1, 5'd15, 16'h8001), 32'hFFFF_FFFF, 32'h0, 1, 5'd15, 32'h0000_8001, "R6 andi");
    issue(1, i_ins(6'h0D, 5'd1, 5'd16, 16'h8000), 32'h1234_0000, 32'h0, 1, 5'd16, 32'h1234_8000, "R6 ori");
    // R7 upper immediate, rs_val ignored
    issue(1, i_ins(6'h0F, 5'd7, 5'd17, 16'hBEEF), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 5'd17, 32'hBEEF_0000, "R7 lui");
    // R8 R-type destination from bits 15:11 with a different rt field
    issue(1, r_ins(5'd21, 5'd21, 5'd22, 5'd0, 6'h25), 32'h1, 32'h2, 1, 5'd22, 32'h3, "R8 rtype dest");
    // R9 rejected encodings
    issue(1, r_ins(5'd1, 5'd2, 5'd3, 5'd0, 6'h24), 32'h5, 32'h7, 0, 5'd3, 32'h0, "R9 funct 0x24");
    issue(1, r_ins(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'h5, 32'h7, 0, 5'd3, 32'h0, "R9 funct 0x20");
    issue(1, i_ins(6'h08, 5'd1, 5'd4, 16'h0005), 32'h5, 32'h7, 0, 5'd4, 32'h0, "R9 opcode 0x08");
    issue(1, i_ins(6'h23, 5'd1, 5'd4, 16'h0004), 32'h5, 32'h7, 0, 5'd4, 32'h0, "R9 load opcode");
    issue(1, i_ins(6'h04, 5'd1, 5'd4, 16'h0004), 32'h5, 32'h5, 0, 5'd4, 32'h0, "R9 branch opcode");
    issue(1, r_ins(5'd1, 5'd2, 5'd25, 5'd0, 6'h21), 32'h1, 32'h1, 1, 5'd25, 32'h2, "R9 neighbour write");
    // R10 register 0 destinations, between ordinary writes
    issue(1, r_ins(5'd1, 5'd2, 5'd0, 5'd0, 6'h21), 32'h5, 32'h7, 0, 5'd0, 32'h0, "R10 add to r0");
    issue(1, r_ins(5'd1, 5'd2, 5'd26, 5'd0, 6'h23), 32'h9, 32'h4, 1, 5'd26, 32'h5, "R10 neighbour write");
    issue(1, i_ins(6'h0F, 5'd1, 5'd0, 16'h1234), 32'h0, 32'h0, 0, 5'd0, 32'h0, "R10 lui to r0");
    // R11 invalid input with a legal word produces no valid and no write
    idle();
    issue(1, i_ins(6'h0D, 5'd1, 5'd27, 16'h00F0), 32'h0000_000F, 32'h0, 1, 5'd27, 32'h0000_00FF, "R11 after idle");
    idle();
    idle();
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule